// File: doc/BRIEF.md
# DDR2 SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of a DDR2 SDRAM channel and owns the command bus from reset until the memory can take normal traffic. While the supplies settle it keeps the clock enable and on-die termination low. Once the power-stable indication has been high for long enough, it raises the clock enable. It then issues a fixed chain of commands: precharge-all, the writes to the three extended mode registers, the mode register write that resets the DLL, a second precharge-all, a parameterized number of auto-refreshes and the run-mode write. It finishes with the driver-impedance default and exit writes. After that it raises a ready flag and holds the bus idle.

Every delay is a parameter. The long power and clock-enable waits are given in nanoseconds and turned into cycles from the clock period. The command-to-command gaps and the DLL settling window are given in cycles. The mode register contents come from configuration inputs. The sequencer forces the few bits that the sequence owns: DLL enable, DLL reset and the impedance-calibration field.

Top module: `ddr2_powerup_seq`

## Requirements
- R1: During reset, and until the power window has completed, cke, odt and init_done are low, the command pins show NOP ({cs_n,ras_n,cas_n,we_n}=0111), and ba and addr are zero.
- R2: cke rises in the cycle after the PWR_CYC-th consecutive clock edge at which pwr_stable is sampled high. A low sample restarts the count. Once high, cke stays high.
- R3: After cke rises, only NOP is driven for CKE_CYC cycles. In the next cycle a precharge-all is issued (pins 0010, addr bit 10 high, all other addr bits and ba zero).
- R4: The next two commands are mode writes (pins 0000) to bank 10 with addr = cfg_emr2, then to bank 11 with addr = cfg_emr3.
- R5: The next command is a mode write to bank 01 with addr = cfg_emr1, but with bit 0 cleared (DLL enabled) and bits 9:7 cleared.
- R6: The next command is a mode write to bank 00 with addr = cfg_mr and bit 8 set (DLL reset).
- R7: The next command is a precharge-all, followed by N_REFRESH auto-refresh commands (pins 0001, ba and addr zero).
- R8: The next command is a mode write to bank 00 with addr = cfg_mr and bit 8 cleared.
- R9: The next command is a mode write to bank 01 with addr = cfg_emr1, bit 0 cleared and bits 9:7 set. It is issued at the later of two cycles: T_MRD_CYC cycles after the R8 write, or DLL_WAIT_CYC cycles after the R6 write.
- R10: The next command is a mode write to bank 01 with addr = cfg_emr1, bit 0 cleared and bits 9:7 cleared.
- R11: Outside the gating of R9, each command follows the previous one by exactly its gap: T_RP_CYC after a precharge-all, T_RFC_CYC after a refresh, T_MRD_CYC after a mode write. Every cycle in between shows NOP with ba and addr zero.
- R12: init_done rises T_MRD_CYC cycles after the R10 write and stays high. From then on only NOP is driven and cke stays high.
- R13: odt is low in every cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_stable | input | 1 | Supplies and clock are stable |
| cfg_mr | input | ADDR_W | Operating value for the mode register |
| cfg_emr1 | input | ADDR_W | Operating value for extended mode register 1 |
| cfg_emr2 | input | ADDR_W | Value for extended mode register 2 |
| cfg_emr3 | input | ADDR_W | Value for extended mode register 3 |
| cke | output | 1 | Clock enable to the memory |
| odt | output | 1 | On-die termination control |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | 2 | Bank address, selects the mode register |
| addr | output | ADDR_W | Address bus carrying mode register contents |
| init_done | output | 1 | Initialization complete |

## Verification
A wrong step, gap count or refresh count shows at the ports in the very cycle of the next command. That command arrives early, arrives late, or carries the wrong bank or address. A miscounted DLL window shifts only the impedance-default write and everything after it. A bad power-window count moves the rise of cke. Because the bench model predicts every pin in every cycle, the first such cycle is reported.

// File: rtl/ddr2_init_pkg.sv
package ddr2_init_pkg;

  typedef enum logic [3:0] {
    ST_PWR, ST_CKE, ST_PREA1, ST_EMR2, ST_EMR3, ST_EMR1_DLL, ST_MR_DLLRST,
    ST_PREA2, ST_REF, ST_MR_RUN, ST_OCD_DEF, ST_OCD_EXIT, ST_DONE
  } step_t;

  typedef enum logic [1:0] {CMD_NOP, CMD_PREA, CMD_REF, CMD_MODE} cmd_t;

  // {cs_n, ras_n, cas_n, we_n}
  localparam logic [3:0] PINS_NOP  = 4'b0111;
  localparam logic [3:0] PINS_PREA = 4'b0010;
  localparam logic [3:0] PINS_REF  = 4'b0001;
  localparam logic [3:0] PINS_MODE = 4'b0000;

  function automatic int ns_to_cycles(int ns, int period_ps);
    return (ns * 1000 + period_ps - 1) / period_ps;
  endfunction

  function automatic int min3(int a, int b, int c);
    int m;
    m = (a < b) ? a : b;
    return (m < c) ? m : c;
  endfunction

  function automatic int max4(int a, int b, int c, int d);
    int m;
    m = (a > b) ? a : b;
    m = (m > c) ? m : c;
    return (m > d) ? m : d;
  endfunction

  function automatic cmd_t step_cmd(step_t s);
    case (s)
      ST_PREA1, ST_PREA2: return CMD_PREA;
      ST_REF:             return CMD_REF;
      ST_EMR2, ST_EMR3, ST_EMR1_DLL, ST_MR_DLLRST,
      ST_MR_RUN, ST_OCD_DEF, ST_OCD_EXIT: return CMD_MODE;
      default:            return CMD_NOP;
    endcase
  endfunction

  function automatic logic [1:0] step_bank(step_t s);
    case (s)
      ST_EMR2:                            return 2'b10;
      ST_EMR3:                            return 2'b11;
      ST_EMR1_DLL, ST_OCD_DEF, ST_OCD_EXIT: return 2'b01;
      default:                            return 2'b00;
    endcase
  endfunction

  function automatic logic [3:0] cmd_pins(cmd_t c);
    case (c)
      CMD_PREA: return PINS_PREA;
      CMD_REF:  return PINS_REF;
      CMD_MODE: return PINS_MODE;
      default:  return PINS_NOP;
    endcase
  endfunction

  function automatic step_t next_step(step_t s);
    case (s)
      ST_PWR:       return ST_CKE;
      ST_CKE:       return ST_PREA1;
      ST_PREA1:     return ST_EMR2;
      ST_EMR2:      return ST_EMR3;
      ST_EMR3:      return ST_EMR1_DLL;
      ST_EMR1_DLL:  return ST_MR_DLLRST;
      ST_MR_DLLRST: return ST_PREA2;
      ST_PREA2:     return ST_REF;
      ST_REF:       return ST_MR_RUN;
      ST_MR_RUN:    return ST_OCD_DEF;
      ST_OCD_DEF:   return ST_OCD_EXIT;
      default:      return ST_DONE;
    endcase
  endfunction

endpackage

// File: rtl/init_pwr_window.sv
module init_pwr_window
  import ddr2_init_pkg::*;
#(
  parameter int PWR_CYC = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic armed,
  input  logic pwr_stable,
  output logic win_done
);
  localparam int CW = $clog2(PWR_CYC + 1);

  logic [CW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   run_q <= '0;
    else if (!armed || !pwr_stable) run_q <= '0;
    else if (run_q != CW'(PWR_CYC)) run_q <= run_q + 1'b1;
  end

  assign win_done = armed && pwr_stable && (run_q == CW'(PWR_CYC - 1));

endmodule

// File: rtl/init_step_fsm.sv
module init_step_fsm
  import ddr2_init_pkg::*;
#(
  parameter int CKE_CYC  = 40,
  parameter int T_RP     = 3,
  parameter int T_MRD    = 2,
  parameter int T_RFC    = 13,
  parameter int N_REF    = 2,
  parameter int DLL_WAIT = 200
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  win_done,
  output step_t step_o,
  output logic  issue_o
);
  localparam int GAP_MAX = max4(CKE_CYC, T_RP, T_MRD, T_RFC);
  localparam int GW      = $clog2(GAP_MAX + 1);
  localparam int RW      = $clog2(N_REF + 1);
  localparam int DW      = $clog2(DLL_WAIT + 1);

  step_t          step_q;
  logic [GW-1:0]  cnt_q;
  logic [RW-1:0]  ref_q;
  logic [DW-1:0]  dll_q;
  logic           dll_ok;
  logic           gate_ok;
  logic           gap_end;
  logic           dll_rst_issue;

  function automatic logic [GW-1:0] gap_of(step_t s);
    case (s)
      ST_CKE:             return GW'(CKE_CYC);
      ST_PREA1, ST_PREA2: return GW'(T_RP);
      ST_REF:             return GW'(T_RFC);
      default:            return GW'(T_MRD);
    endcase
  endfunction

  assign dll_ok        = (dll_q == DW'(DLL_WAIT));
  assign gate_ok       = (step_q != ST_OCD_DEF) || (cnt_q != '0) || dll_ok;
  assign gap_end       = (cnt_q == gap_of(step_q) - 1'b1);
  assign issue_o       = (step_cmd(step_q) != CMD_NOP) && (cnt_q == '0) && gate_ok;
  assign dll_rst_issue = issue_o && (step_q == ST_MR_DLLRST);
  assign step_o        = step_q;

  // cycles elapsed since the DLL-reset write, saturating at the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                   dll_q <= '0;
    else if (dll_rst_issue)                       dll_q <= DW'(1);
    else if (dll_q != '0 && dll_q != DW'(DLL_WAIT)) dll_q <= dll_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q <= ST_PWR;
      cnt_q  <= '0;
      ref_q  <= '0;
    end else if (step_q == ST_PWR) begin
      if (win_done) step_q <= ST_CKE;
    end else if (step_q != ST_DONE && gate_ok) begin
      if (gap_end) begin
        cnt_q <= '0;
        if (step_q == ST_REF && ref_q != RW'(N_REF - 1)) begin
          ref_q <= ref_q + 1'b1;
        end else begin
          ref_q  <= '0;
          step_q <= next_step(step_q);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

endmodule

// File: rtl/init_cmd_encode.sv
module init_cmd_encode
  import ddr2_init_pkg::*;
#(
  parameter int ADDR_W = 13
) (
  input  step_t             step,
  input  logic              issue,
  input  logic [ADDR_W-1:0] cfg_mr,
  input  logic [ADDR_W-1:0] cfg_emr1,
  input  logic [ADDR_W-1:0] cfg_emr2,
  input  logic [ADDR_W-1:0] cfg_emr3,
  output logic [3:0]        pins,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr
);
  localparam logic [ADDR_W-1:0] DLL_OFF_BIT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] DLL_RST_BIT = ADDR_W'(1) << 8;
  localparam logic [ADDR_W-1:0] OCD_FIELD   = ADDR_W'(7) << 7;
  localparam logic [ADDR_W-1:0] ALL_BANKS   = ADDR_W'(1) << 10;

  function automatic logic [ADDR_W-1:0] word_for(step_t s);
    logic [ADDR_W-1:0] emr1_base;
    emr1_base = cfg_emr1 & ~DLL_OFF_BIT & ~OCD_FIELD;
    case (s)
      ST_PREA1, ST_PREA2:      return ALL_BANKS;
      ST_EMR2:                 return cfg_emr2;
      ST_EMR3:                 return cfg_emr3;
      ST_EMR1_DLL, ST_OCD_EXIT: return emr1_base;
      ST_OCD_DEF:              return emr1_base | OCD_FIELD;
      ST_MR_DLLRST:            return cfg_mr | DLL_RST_BIT;
      ST_MR_RUN:               return cfg_mr & ~DLL_RST_BIT;
      default:                 return '0;
    endcase
  endfunction

  always_comb begin
    pins = PINS_NOP;
    ba   = 2'b00;
    addr = '0;
    if (issue) begin
      pins = cmd_pins(step_cmd(step));
      ba   = step_bank(step);
      addr = word_for(step);
    end
  end

endmodule

// File: rtl/ddr2_powerup_seq.sv
module ddr2_powerup_seq
  import ddr2_init_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 10000,
  parameter int T_PWR_NS      = 200000,
  parameter int T_CKE_NS      = 400,
  parameter int T_RP_CYC      = 3,
  parameter int T_MRD_CYC     = 2,
  parameter int T_RFC_CYC     = 13,
  parameter int N_REFRESH     = 2,
  parameter int DLL_WAIT_CYC  = 200,
  parameter int ADDR_W        = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_stable,
  input  logic [ADDR_W-1:0] cfg_mr,
  input  logic [ADDR_W-1:0] cfg_emr1,
  input  logic [ADDR_W-1:0] cfg_emr2,
  input  logic [ADDR_W-1:0] cfg_emr3,
  output logic              cke,
  output logic              odt,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic [1:0]        ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  localparam int PWR_CYC = ns_to_cycles(T_PWR_NS, CLK_PERIOD_PS);
  localparam int CKE_CYC = ns_to_cycles(T_CKE_NS, CLK_PERIOD_PS);
  localparam int MIN_GAP = min3(T_RP_CYC, T_MRD_CYC, T_RFC_CYC);
  localparam int SW      = $clog2(MIN_GAP + 1);
  localparam int DW      = $clog2(DLL_WAIT_CYC + 1);

  step_t      step;
  logic       issue;
  logic       win_done;
  logic [3:0] pins;

  init_pwr_window #(.PWR_CYC(PWR_CYC)) u_pwr (
    .clk(clk), .rst_n(rst_n), .armed(step == ST_PWR),
    .pwr_stable(pwr_stable), .win_done(win_done)
  );

  init_step_fsm #(
    .CKE_CYC(CKE_CYC), .T_RP(T_RP_CYC), .T_MRD(T_MRD_CYC),
    .T_RFC(T_RFC_CYC), .N_REF(N_REFRESH), .DLL_WAIT(DLL_WAIT_CYC)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .win_done(win_done),
    .step_o(step), .issue_o(issue)
  );

  init_cmd_encode #(.ADDR_W(ADDR_W)) u_enc (
    .step(step), .issue(issue),
    .cfg_mr(cfg_mr), .cfg_emr1(cfg_emr1), .cfg_emr2(cfg_emr2), .cfg_emr3(cfg_emr3),
    .pins(pins), .ba(ba), .addr(addr)
  );

  assign {cs_n, ras_n, cas_n, we_n} = pins;
  assign cke       = (step != ST_PWR);
  assign odt       = 1'b0;
  assign init_done = (step == ST_DONE);

  // Port-level event wires for the checks below
  logic cmd_any, dllrst_seen, ocd_def_seen;
  assign cmd_any      = (pins != PINS_NOP);
  assign dllrst_seen  = (pins == PINS_MODE) && (ba == 2'b00) && addr[8];
  assign ocd_def_seen = (pins == PINS_MODE) && (ba == 2'b01) && (addr[9:7] == 3'b111);

  logic [SW-1:0] since_cmd;
  logic [DW-1:0] since_dll;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       since_cmd <= SW'(MIN_GAP);
    else if (cmd_any)                 since_cmd <= SW'(1);
    else if (since_cmd != SW'(MIN_GAP)) since_cmd <= since_cmd + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 since_dll <= '0;
    else if (dllrst_seen)       since_dll <= DW'(1);
    else if (since_dll != '0 && since_dll != DW'(DLL_WAIT_CYC)) since_dll <= since_dll + 1'b1;
  end

  // R1
  cmd_while_cke_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cke |-> (pins == PINS_NOP));

  // R2
  cke_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cke |=> cke);

  // R9
  ocd_after_dll_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ocd_def_seen |-> (since_dll == DW'(DLL_WAIT_CYC)));

  // R11
  cmd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_any |-> (since_cmd == SW'(MIN_GAP)));

  // R12
  ready_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R12
  quiet_after_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |-> (pins == PINS_NOP && cke));

endmodule

// File: tb/test_ddr2_powerup_seq.sv
module test_ddr2_powerup_seq;

  localparam int PER_PS = 10000;
  localparam int PWR_NS = 2000;
  localparam int CKE_NS = 400;
  localparam int RP = 3, MRD = 2, RFC = 8, NREF = 2, DLLW = 200;
  localparam int B_PWR = (PWR_NS * 1000) / PER_PS + (((PWR_NS * 1000) % PER_PS) != 0 ? 1 : 0);
  localparam int B_CKE = (CKE_NS * 1000) / PER_PS + (((CKE_NS * 1000) % PER_PS) != 0 ? 1 : 0);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_stable = 1'b0;
  logic [12:0] cfg_mr = '0, cfg_emr1 = '0, cfg_emr2 = '0, cfg_emr3 = '0;
  logic cke, odt, cs_n, ras_n, cas_n, we_n, init_done;
  logic [1:0] ba;
  logic [12:0] addr;

  always #5 clk = ~clk;

  ddr2_powerup_seq #(
    .CLK_PERIOD_PS(PER_PS), .T_PWR_NS(PWR_NS), .T_CKE_NS(CKE_NS),
    .T_RP_CYC(RP), .T_MRD_CYC(MRD), .T_RFC_CYC(RFC),
    .N_REFRESH(NREF), .DLL_WAIT_CYC(DLLW), .ADDR_W(13)
  ) i_ddr2_powerup_seq (
    .clk(clk), .rst_n(rst_n), .pwr_stable(pwr_stable),
    .cfg_mr(cfg_mr), .cfg_emr1(cfg_emr1), .cfg_emr2(cfg_emr2), .cfg_emr3(cfg_emr3),
    .cke(cke), .odt(odt), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .ba(ba), .addr(addr), .init_done(init_done)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, run = 0, t_cke = -1, t_done = -1;
  int q_t[$];
  logic [3:0]  q_pins[$];
  logic [1:0]  q_ba[$];
  logic [12:0] q_addr[$];
  string       q_tag[$];

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", tag, what, cyc, act, exp);
    end
  endtask

  task automatic push(input int t, input logic [3:0] p, input logic [1:0] b,
                      input logic [12:0] a, input string tag);
    q_t.push_back(t); q_pins.push_back(p); q_ba.push_back(b);
    q_addr.push_back(a); q_tag.push_back(tag);
  endtask

  // Expected command timeline from the cycle cke rises
  task automatic build(input int t0);
    int t, tr;
    t = t0 + B_CKE;
    push(t, 4'b0010, 2'b00, 13'h0400, "R3");                 t += RP;
    push(t, 4'b0000, 2'b10, cfg_emr2, "R4");                 t += MRD;
    push(t, 4'b0000, 2'b11, cfg_emr3, "R4");                 t += MRD;
    push(t, 4'b0000, 2'b01, cfg_emr1 & ~13'h0381, "R5");     t += MRD;
    tr = t;
    push(t, 4'b0000, 2'b00, cfg_mr | 13'h0100, "R6");        t += MRD;
    push(t, 4'b0010, 2'b00, 13'h0400, "R7");                 t += RP;
    for (int i = 0; i < NREF; i++) begin
      push(t, 4'b0001, 2'b00, 13'h0000, "R7");               t += RFC;
    end
    push(t, 4'b0000, 2'b00, cfg_mr & ~13'h0100, "R8");       t += MRD;
    if (t < tr + DLLW) t = tr + DLLW;
    push(t, 4'b0000, 2'b01, (cfg_emr1 & ~13'h0001) | 13'h0380, "R9"); t += MRD;
    push(t, 4'b0000, 2'b01, cfg_emr1 & ~13'h0381, "R10");    t += MRD;
    t_done = t;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      run = 0; t_cke = -1; t_done = -1;
      q_t.delete(); q_pins.delete(); q_ba.delete(); q_addr.delete(); q_tag.delete();
    end else if (t_cke < 0) begin
      run = pwr_stable ? run + 1 : 0;
      if (run == B_PWR) begin
        t_cke = cyc;
        build(cyc);
      end
    end
  end

  always @(negedge clk) begin
    if (cyc >= 1) begin
      if (!rst_n) begin
        chk("R1", "pins", {cs_n, ras_n, cas_n, we_n}, 4'b0111);
        chk("R1", "ba", ba, 0);
        chk("R1", "addr", addr, 0);
        chk("R1", "cke", cke, 0);
        chk("R1", "init_done", init_done, 0);
        chk("R13", "odt", odt, 0);
      end else begin
        logic [3:0] ep; logic [1:0] eb; logic [12:0] ea; string tg;
        ep = 4'b0111; eb = 2'b00; ea = '0;
        tg = (t_cke < 0) ? "R1" : ((t_done >= 0 && cyc >= t_done) ? "R12" : "R11");
        if (q_t.size() > 0 && q_t[0] == cyc) begin
          ep = q_pins[0]; eb = q_ba[0]; ea = q_addr[0]; tg = q_tag[0];
          void'(q_t.pop_front()); void'(q_pins.pop_front()); void'(q_ba.pop_front());
          void'(q_addr.pop_front()); void'(q_tag.pop_front());
        end
        chk(tg, "pins", {cs_n, ras_n, cas_n, we_n}, ep);
        chk(tg, "ba", ba, eb);
        chk(tg, "addr", addr, ea);
        chk("R2", "cke", cke, (t_cke >= 0 && cyc >= t_cke) ? 1 : 0);
        chk("R12", "init_done", init_done, (t_done >= 0 && cyc >= t_done) ? 1 : 0);
        chk("R13", "odt", odt, 0);
      end
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #2;
  endtask

  task automatic wait_ready();
    int guard = 0;
    while (!init_done && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    #2;
    if (!init_done) chk("R12", "ready reached", 0, 1);
    wait_cycles(30);
  endtask

  initial begin
    // Run 1: power window interrupted once (R2 restart)
    cfg_mr = 13'h0A53; cfg_emr1 = 13'h1385; cfg_emr2 = 13'h0080; cfg_emr3 = 13'h0000;
    wait_cycles(5);
    rst_n = 1'b1;
    wait_cycles(40);
    pwr_stable = 1'b1;
    wait_cycles(120);
    pwr_stable = 1'b0;
    wait_cycles(3);
    pwr_stable = 1'b1;
    wait_ready();

    // Run 2: new configuration with the forced bits set the other way
    rst_n = 1'b0;
    cfg_mr = 13'h1532; cfg_emr1 = 13'h0046; cfg_emr2 = 13'h1FFF; cfg_emr3 = 13'h0003;
    wait_cycles(4);
    rst_n = 1'b1;
    wait_ready();

    // Run 3: reset in the middle of the sequence, then a full restart
    rst_n = 1'b0;
    cfg_mr = 13'h0100; cfg_emr1 = 13'h0001; cfg_emr2 = 13'h0111; cfg_emr3 = 13'h0222;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_cycles(B_PWR + B_CKE + 30);
    rst_n = 1'b0;
    wait_cycles(3);
    rst_n = 1'b1;
    wait_ready();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish, actual 0 expected 1");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

endmodule